// File: doc/BRIEF.md
# Nibble ALU with Carry-Driven Serial Clock Pin

This block is the 4-bit arithmetic core of a small sequencer-style controller. An accumulator and a single carry flag are updated once per instruction cycle, on the clock edge where the instruction-cycle strobe is high. The operation code selects one of these actions:

- add the memory operand, with or without the incoming carry
- add the immediate
- load the immediate
- complement the accumulator
- clear the accumulator
- set the carry
- reset the carry

A one-bit clock-control latch drives a serial clock pin. An exchange operation copies the carry into that latch. A mode bit then chooses what the pin shows: in level mode it shows the latched carry, and in pulse mode it gives one clock pulse per instruction cycle while the latched carry is 1. The pulse is high for the first half of the cycle and low for the second half. Instruction cycles are `CYC_CLKS` clocks long and are marked by the strobe.

Top module: `nib_alu_sk`

## Requirements
- R1: The accumulator, carry, control latch and mode change only on a clock edge where `cyc_strobe` is 1; any opcode presented without the strobe leaves all of them unchanged.
- R2: Opcode 1 (add) sets the accumulator to (acc + mem_opd) mod 16 and leaves the carry unchanged.
- R3: Opcode 2 (add with carry) sets the accumulator to (acc + mem_opd + carry) mod 16 and sets the carry to the carry-out of that sum.
- R4: Opcode 3 sets the accumulator to (acc + imm) mod 16 with the carry unchanged; opcode 10 loads imm into the accumulator.
- R5: Opcode 4 replaces the accumulator with its bitwise complement; opcode 5 clears it to 0.
- R6: Opcode 6 sets the carry to 1 and opcode 7 clears it to 0, with the accumulator unchanged.
- R7: Opcode 8 (exchange) copies the carry held before that edge into the clock-control latch. Later carry changes do not reach the pin until the next exchange.
- R8: Opcode 9 sets the pin mode to imm bit 0. In level mode (0) the pin equals the control latch in every clock.
- R9: In pulse mode (1), the pin is high during clocks 0 to CYC_CLKS/2-1 after a strobe edge and low during the rest of the cycle, and only while the control latch is 1. After the cycle ends with no new strobe, it stays low.
- R10: While rst_n is low, the accumulator, carry, control latch, mode and pin are all 0.
- R11: Opcodes 0 and 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_strobe | input | 1 | Marks the first clock of an instruction cycle; the opcode executes on this edge |
| op | input | 4 | Operation code |
| mem_opd | input | W | Memory operand |
| imm | input | W | Immediate value |
| acc | output | W | Accumulator |
| carry | output | 1 | Carry flag |
| sclk_o | output | 1 | Serial clock pin |

## Verification
Two things can land on the same edge: an exchange that reloads the clock-control latch, and the restart of the phase counter that begins a new pulse. Both happen on every strobe edge that carries opcode 8. The bench provokes this on purpose. It first sets the carry, or adds with carry so the sum overflows, and then issues an exchange while the pin is in pulse mode. It then checks the pin in each clock of that cycle: it must already follow the new latch value in clock 0 and fall at the half-cycle point. The opposite case is checked as well: the carry is changed after an exchange, and the pin must keep showing the old latched value.

// File: rtl/nib_alu_pkg.sv
// Package: operation codes shared by the nibble ALU and its checker.
package nib_alu_pkg;
    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADC  = 4'd2,
        OP_ADDI = 4'd3,
        OP_COMP = 4'd4,
        OP_CLRA = 4'd5,
        OP_SETC = 4'd6,
        OP_RSTC = 4'd7,
        OP_XAS  = 4'd8,
        OP_SETM = 4'd9,
        OP_LDI  = 4'd10
    } nib_op_e;
endpackage

// File: rtl/nib_adder.sv
// Module: nib_adder
// Ripple-carry adder of W bits built from a generate loop.
// Assumes: purely combinational; the caller registers the result.
module nib_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Full adder for bit i.
        assign sum[i]  = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end

    assign cout = cy[W];
endmodule

// File: rtl/nib_acc_unit.sv
// Module: nib_acc_unit
// Holds the accumulator and the carry flag and applies one operation on each
// executing edge.
// Assumes: exec is high for exactly one clock per instruction cycle; the
// reset is synchronous and active low.
module nib_acc_unit
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec,
    input  nib_op_e      op_e,
    input  logic [W-1:0] mem_opd,
    input  logic [W-1:0] imm,
    output logic [W-1:0] acc_q,
    output logic         carry_q
);
    logic [W-1:0] add_b;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] acc_d;
    logic         carry_d;

    // Select the adder operands for the current opcode.
    always_comb begin
        add_b   = (op_e == OP_ADDI) ? imm : mem_opd;
        add_cin = (op_e == OP_ADC) ? carry_q : 1'b0;
    end

    nib_adder #(.W(W)) i_adder (
        .a    (acc_q),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Next-state selection for the accumulator and the carry.
    always_comb begin
        acc_d   = acc_q;
        carry_d = carry_q;
        unique case (op_e)
            OP_ADD, OP_ADDI: acc_d = add_sum;
            OP_ADC: begin
                acc_d   = add_sum;
                carry_d = add_cout;
            end
            OP_COMP: acc_d   = ~acc_q;
            OP_CLRA: acc_d   = '0;
            OP_LDI:  acc_d   = imm;
            OP_SETC: carry_d = 1'b1;
            OP_RSTC: carry_d = 1'b0;
            default: ;
        endcase
    end

    // Register the accumulator and carry on executing edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (exec) begin
            acc_q   <= acc_d;
            carry_q <= carry_d;
        end
    end
endmodule

// File: rtl/nib_phase_ctr.sv
// Module: nib_phase_ctr
// Counts the clocks inside an instruction cycle and flags its first half.
// Assumes: the strobe restarts the count at 0; with no strobe the count
// stops at CYC_CLKS-1 so that the first-half flag stays low.
module nib_phase_ctr #(
    parameter int CYC_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_strobe,
    output logic first_half
);
    localparam int PW   = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_CLKS - 1);
    localparam logic [PW-1:0] HALF = PW'(CYC_CLKS / 2);

    logic [PW-1:0] ph_q;

    // Restart on the strobe, otherwise count up and stop at the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (cyc_strobe) begin
            ph_q <= '0;
        end else if (ph_q != LAST) begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign first_half = (ph_q < HALF);
endmodule

// File: rtl/nib_sclk_ctl.sv
// Module: nib_sclk_ctl
// Holds the clock-control latch and the pin mode, and forms the pin level.
// Assumes: the latch is loaded only by the exchange opcode, which captures
// the carry present before the edge.
module nib_sclk_ctl
    import nib_alu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    exec,
    input  nib_op_e op_e,
    input  logic    carry_q,
    input  logic    mode_bit,
    input  logic    first_half,
    output logic    ctl_q,
    output logic    mode_q,
    output logic    sclk
);
    // Capture the carry on an exchange and the mode on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (exec) begin
            if (op_e == OP_XAS)  ctl_q  <= carry_q;
            if (op_e == OP_SETM) mode_q <= mode_bit;
        end
    end

    // Level mode passes the latch through; pulse mode gates it with the first half.
    always_comb begin
        sclk = ctl_q & (mode_q ? first_half : 1'b1);
    end
endmodule

// File: rtl/nib_alu_sk.sv
// Module: nib_alu_sk (top)
// Nibble accumulator/carry unit with a serial clock pin controlled by the carry.
// Assumes: cyc_strobe pulses once per instruction cycle of CYC_CLKS clocks;
// the reset is synchronous and active low.
module nib_alu_sk
    import nib_alu_pkg::*;
#(
    parameter int W        = 4,
    parameter int CYC_CLKS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_strobe,
    input  logic [3:0]   op,
    input  logic [W-1:0] mem_opd,
    input  logic [W-1:0] imm,
    output logic [W-1:0] acc,
    output logic         carry,
    output logic         sclk_o
);
    nib_op_e op_e;
    logic    first_half;
    logic    ctl_q;
    logic    mode_q;

    assign op_e = nib_op_e'(op);

    nib_acc_unit #(.W(W)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec    (cyc_strobe),
        .op_e    (op_e),
        .mem_opd (mem_opd),
        .imm     (imm),
        .acc_q   (acc),
        .carry_q (carry)
    );

    nib_phase_ctr #(.CYC_CLKS(CYC_CLKS)) i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_strobe (cyc_strobe),
        .first_half (first_half)
    );

    nib_sclk_ctl i_sclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec       (cyc_strobe),
        .op_e       (op_e),
        .carry_q    (carry),
        .mode_bit   (imm[0]),
        .first_half (first_half),
        .ctl_q      (ctl_q),
        .mode_q     (mode_q),
        .sclk       (sclk_o)
    );
endmodule

// File: rtl/nib_alu_sk_chk.sv
// Module: nib_alu_sk_chk
// Checker bound to nib_alu_sk; it observes the ports plus the latch and mode.
module nib_alu_sk_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cyc_strobe,
    input logic [3:0]   op,
    input logic [W-1:0] acc,
    input logic         carry,
    input logic         sclk_o,
    input logic         ctl_q,
    input logic         mode_q
);
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (acc == '0 && !carry && !sclk_o && !ctl_q && !mode_q));

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_strobe |=> ($stable(acc) && $stable(carry) && $stable(ctl_q) && $stable(mode_q)));

    assert_add_keeps_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && op == 4'd1) |=> $stable(carry));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && op == 4'd5) |=> (acc == '0));

    assert_setc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && op == 4'd6) |=> carry);

    assert_xas_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && op == 4'd8) |=> (ctl_q == $past(carry)));

    assert_level_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (sclk_o == ctl_q));

    assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strobe |=> (sclk_o == ctl_q));

    assert_pin_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> ctl_q);
endmodule

bind nib_alu_sk nib_alu_sk_chk #(.W(W)) i_nib_alu_sk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_strobe (cyc_strobe),
    .op         (op),
    .acc        (acc),
    .carry      (carry),
    .sclk_o     (sclk_o),
    .ctl_q      (ctl_q),
    .mode_q     (mode_q)
);

// File: tb/test_nib_alu_sk.sv
module test_nib_alu_sk;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int CYC        = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cyc_strobe = 1'b0;
    logic [3:0]   op = 4'd0;
    logic [W-1:0] mem_opd = '0;
    logic [W-1:0] imm = '0;
    logic [W-1:0] acc;
    logic         carry;
    logic         sclk_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state
    logic [W-1:0] ea = '0;
    logic         ec = 1'b0;
    logic         ectl = 1'b0;
    logic         emode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_alu_sk #(.W(W), .CYC_CLKS(CYC)) i_nib_alu_sk (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .op(op),
        .mem_opd(mem_opd), .imm(imm), .acc(acc), .carry(carry), .sclk_o(sclk_o)
    );

    function automatic logic exp_pin(input logic ctl, input logic md, input int k);
        return ctl & (md ? (k < CYC/2) : 1'b1);
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd10: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [3:0] o, input logic [W-1:0] m, input logic [W-1:0] im);
        logic [W:0] s;
        case (o)
            4'd1: ea = ea + m;
            4'd2: begin s = {1'b0, ea} + {1'b0, m} + {{W{1'b0}}, ec}; ea = s[W-1:0]; ec = s[W]; end
            4'd3: ea = ea + im;
            4'd4: ea = ~ea;
            4'd5: ea = '0;
            4'd6: ec = 1'b1;
            4'd7: ec = 1'b0;
            4'd8: ectl = ec;
            4'd9: emode = im[0];
            4'd10: ea = im;
            default: ;
        endcase
    endtask

    // One instruction cycle: execute on the strobe edge, then check state and pin per clock.
    task automatic run_op(input logic [3:0] o, input logic [W-1:0] m, input logic [W-1:0] im);
        string r;
        r = req_of(o);
        @(negedge clk);
        cyc_strobe = 1'b1; op = o; mem_opd = m; imm = im;
        @(posedge clk);
        model(o, m, im);
        @(negedge clk);
        cyc_strobe = 1'b0; op = 4'd0;
        check(r, "acc", int'(acc), int'(ea));
        check(r, "carry", int'(carry), int'(ec));
        for (int k = 0; k < CYC; k++) begin
            if (k > 0) @(negedge clk);
            check(emode ? "R9" : "R8", "pin", int'(sclk_o), int'(exp_pin(ectl, emode, k)));
        end
    endtask

    // Present an opcode without the strobe: nothing may change (R1).
    task automatic idle_op(input logic [3:0] o, input logic [W-1:0] m);
        @(negedge clk);
        cyc_strobe = 1'b0; op = o; mem_opd = m; imm = m;
        @(negedge clk);
        op = 4'd0;
        check("R1", "acc hold", int'(acc), int'(ea));
        check("R1", "carry hold", int'(carry), int'(ec));
        check("R1", "pin hold", int'(sclk_o), int'(exp_pin(ectl, emode, CYC)));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        check("R10", "reset acc", int'(acc), 0);
        check("R10", "reset carry", int'(carry), 0);
        check("R10", "reset pin", int'(sclk_o), 0);
        rst_n = 1'b1;

        // Directed: loads and arithmetic
        run_op(4'd10, 4'd0, 4'd9);          // R4 load 9
        run_op(4'd1, 4'd8, 4'd0);           // R2 9+8 wraps to 1, carry stays 0
        run_op(4'd10, 4'd0, 4'd15);
        run_op(4'd2, 4'd1, 4'd0);           // R3 15+1 -> 0, carry 1
        run_op(4'd2, 4'd0, 4'd0);           // R3 0+0+1 -> 1, carry 0
        run_op(4'd6, 4'd0, 4'd0);           // R6 set carry
        run_op(4'd1, 4'd15, 4'd0);          // R2 carry unchanged at 1
        run_op(4'd3, 4'd0, 4'd15);          // R4 addi
        run_op(4'd4, 4'd0, 4'd0);           // R5 complement
        run_op(4'd5, 4'd0, 4'd0);           // R5 clear
        // Level mode then exchange
        run_op(4'd8, 4'd0, 4'd0);           // R7 latch carry=1
        run_op(4'd7, 4'd0, 4'd0);           // R7 carry 0, pin keeps 1
        run_op(4'd9, 4'd0, 4'd1);           // R9 pulse mode
        run_op(4'd0, 4'd0, 4'd0);           // R11 nop, pulse continues
        run_op(4'd8, 4'd0, 4'd0);           // R7 latch 0 -> pin off
        run_op(4'd10, 4'd0, 4'd15);
        run_op(4'd2, 4'd1, 4'd0);           // carry set by overflow
        run_op(4'd8, 4'd0, 4'd0);           // exchange with phase restart
        run_op(4'd13, 4'd3, 4'd3);          // R11 undefined opcode
        idle_op(4'd7, 4'd2);                // R1 reset-carry without strobe
        idle_op(4'd8, 4'd0);                // R1 exchange without strobe
        run_op(4'd9, 4'd0, 4'd0);           // R8 back to level mode
        idle_op(4'd5, 4'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] ro;
            ro = 4'($urandom_range(0, 15));
            if (($urandom % 8) == 0) idle_op(ro, 4'($urandom));
            else run_op(ro, 4'($urandom), 4'($urandom));
        end

        // Reset mid-run
        run_op(4'd6, 4'd0, 4'd0);
        run_op(4'd8, 4'd0, 4'd0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        ea = '0; ec = 1'b0; ectl = 1'b0; emode = 1'b0;
        check("R10", "reset acc", int'(acc), 0);
        check("R10", "reset carry", int'(carry), 0);
        check("R10", "reset pin", int'(sclk_o), 0);
        rst_n = 1'b1;
        run_op(4'd0, 4'd0, 4'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule